// File: doc/BRIEF.md
# Dual-Bank Memory Window Mapper

This block turns a host memory address that falls inside a video aperture into an address in a 1 MB video memory. Two 7-bit bank offsets, A and B, each select a 4 KB-aligned page base. The offset in use is picked either by the direction of the access or by which half of the aperture the address falls in. A two-bit map field chooses the aperture. Setting 0 gives the legacy window at A0000h, which is 64 KB or 128 KB wide. Settings 1, 2 and 3 give linear windows that start at zero and are 256 KB, 512 KB and 1 MB wide.

The block sits between the host bus decoder and the video memory controller. The offsets and control bits come from registers that are programmed elsewhere. The `hit` output tells the bus decoder to claim the cycle, and `vaddr` goes to the memory controller. The parameter `REG_OUT` selects one of two variants. With `REG_OUT` clear, the outputs are combinational. With `REG_OUT` set, the outputs are registered and appear one clock later.

Top module: `bank_window_mapper`

## Requirements
- R1: With map field 0 and `wide_win` low, `hit` is 1 exactly for addresses A0000h through AFFFFh.
- R2: With map field 0 and `wide_win` high, `hit` is 1 exactly for addresses A0000h through BFFFFh.
- R3: With map field 1, 2 or 3, `hit` is 1 exactly for addresses below 40000h, 80000h or 100000h respectively. Map field 3 therefore hits every address.
- R4: On a hit, `vaddr` equals (host address minus window base) plus the selected offset times 4096. The window base is A0000h for map field 0 and 0 for the other settings.
- R5: With `bankb_en` high and `split_rw` high, reads (`is_write`=0) use offset A and writes (`is_write`=1) use offset B. This holds in both halves of the window.
- R6: With `bankb_en` high and `split_rw` low, the lower half of the window uses offset B and the upper half uses offset A. The halves split at A8000h (map 0, narrow), B0000h (map 0, wide), 20000h, 40000h and 80000h (maps 1 to 3).
- R7: With `bankb_en` low, offset A is used for every access, whatever `split_rw`, `is_write` and the half are.
- R8: The sum in R4 wraps modulo 2^20.
- R9: With `REG_OUT`=0, the outputs follow the inputs within the same cycle. With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `hit` and `vaddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 20 | Host byte address |
| is_write | input | 1 | 1 for a write cycle, 0 for a read |
| ofs_a | input | 7 | Bank A page offset (4 KB units) |
| ofs_b | input | 7 | Bank B page offset (4 KB units) |
| split_rw | input | 1 | Choose bank by direction instead of by half |
| bankb_en | input | 1 | Allow bank B; when low, bank A serves everything |
| map_sel | input | 2 | Aperture: 0 legacy, 1 256 KB, 2 512 KB, 3 1 MB linear |
| wide_win | input | 1 | Legacy aperture width: 0 = 64 KB, 1 = 128 KB |
| hit | output | 1 | Address lies inside the selected window |
| vaddr | output | 20 | Translated video memory address |

## Verification
The window decode and the bank choice act on the same address in the same cycle. The decode fixes the half boundary, and the bank choice uses that boundary. The sweep therefore probes both edges of every 2 KB step under all 64 combinations of map, width, split, bank-B enable and direction. The translated address is judged against an arithmetic model that adds the selected offset. Offset A is set to 7Fh in some configurations so that the page addition and the 20-bit wrap fall on the same access. Both the combinational and the registered variants are compared after each edge.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic [1:0] {
    MAP_LEGACY  = 2'd0,
    MAP_LIN256K = 2'd1,
    MAP_LIN512K = 2'd2,
    MAP_LIN1M   = 2'd3
  } map_e;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // Legacy aperture base address.
  localparam logic [19:0] LEGACY_BASE = 20'hA0000;
  // Linear map k covers 2**(LIN_SHIFT_BASE + k) bytes.
  localparam int LIN_SHIFT_BASE = 17;
  // Legacy window sizes as log2 of bytes.
  localparam int LEG_NARROW_LOG = 16;
  localparam int LEG_WIDE_LOG   = 17;

endpackage

// File: rtl/bwm_window.sv
module bwm_window
  import bwm_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] host_addr,
  input  map_e          map_sel,
  input  logic          wide_win,
  output logic          hit,
  output logic          upper,
  output logic [AW-1:0] local_addr
);

  localparam logic [AW-1:0] LEG_BASE = AW'(LEGACY_BASE);

  logic [3:0]    lin_hit;
  logic [3:0]    lin_upper;
  logic          leg_hit_n, leg_hit_w;
  logic [AW-1:0] base;

  assign lin_hit[0]   = 1'b0;
  assign lin_upper[0] = 1'b0;

  // One range detector per linear map size.
  for (genvar k = 1; k < 4; k++) begin : g_lin
    localparam int LOG = LIN_SHIFT_BASE + k;
    assign lin_hit[k]   = (host_addr >> LOG) == '0;
    assign lin_upper[k] = host_addr[LOG-1];
  end

  assign leg_hit_n = (host_addr >> LEG_NARROW_LOG) == (LEG_BASE >> LEG_NARROW_LOG);
  assign leg_hit_w = (host_addr >> LEG_WIDE_LOG)   == (LEG_BASE >> LEG_WIDE_LOG);

  always_comb begin
    if (map_sel == MAP_LEGACY) begin
      base  = LEG_BASE;
      hit   = wide_win ? leg_hit_w : leg_hit_n;
      upper = wide_win ? host_addr[LEG_WIDE_LOG-1] : host_addr[LEG_NARROW_LOG-1];
    end else begin
      base  = '0;
      hit   = lin_hit[map_sel];
      upper = lin_upper[map_sel];
    end
  end

  assign local_addr = host_addr - base;

endmodule

// File: rtl/bwm_select.sv
module bwm_select
  import bwm_pkg::*;
(
  input  logic  split_rw,
  input  logic  bankb_en,
  input  logic  is_write,
  input  logic  upper,
  output bank_e sel
);

  always_comb begin
    if (!bankb_en)     sel = BANK_A;
    else if (split_rw) sel = is_write ? BANK_B : BANK_A;
    else               sel = upper ? BANK_A : BANK_B;
  end

endmodule

// File: rtl/bwm_adder.sv
module bwm_adder
  import bwm_pkg::*;
#(
  parameter int AW      = 20,
  parameter int OW      = 7,
  parameter int PAGE_SH = 12
) (
  input  logic [AW-1:0] local_addr,
  input  logic [OW-1:0] ofs_a,
  input  logic [OW-1:0] ofs_b,
  input  bank_e         sel,
  output logic [AW-1:0] vaddr
);

  logic [OW-1:0] ofs;
  logic [AW-1:0] page_base;

  assign ofs       = (sel == BANK_B) ? ofs_b : ofs_a;
  assign page_base = AW'(ofs) << PAGE_SH;
  // Modulo 2**AW by truncation.
  assign vaddr     = local_addr + page_base;

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int AW      = 20,
  parameter int OW      = 7,
  parameter int PAGE_SH = 12,
  parameter bit REG_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          is_write,
  input  logic [OW-1:0] ofs_a,
  input  logic [OW-1:0] ofs_b,
  input  logic          split_rw,
  input  logic          bankb_en,
  input  logic [1:0]    map_sel,
  input  logic          wide_win,
  output logic          hit,
  output logic [AW-1:0] vaddr
);

  logic          hit_c, upper_c;
  logic [AW-1:0] local_c, vaddr_c;
  bank_e         sel_b;

  bwm_window #(.AW(AW)) u_win (
    .host_addr (host_addr),
    .map_sel   (map_e'(map_sel)),
    .wide_win  (wide_win),
    .hit       (hit_c),
    .upper     (upper_c),
    .local_addr(local_c)
  );

  bwm_select u_sel (
    .split_rw(split_rw),
    .bankb_en(bankb_en),
    .is_write(is_write),
    .upper   (upper_c),
    .sel     (sel_b)
  );

  bwm_adder #(.AW(AW), .OW(OW), .PAGE_SH(PAGE_SH)) u_add (
    .local_addr(local_c),
    .ofs_a     (ofs_a),
    .ofs_b     (ofs_b),
    .sel       (sel_b),
    .vaddr     (vaddr_c)
  );

  if (REG_OUT) begin : g_reg
    logic          hit_d, hit_q;
    logic [AW-1:0] vaddr_d, vaddr_q;

    always_comb begin
      hit_d   = hit_c;
      vaddr_d = vaddr_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q   <= 1'b0;
        vaddr_q <= '0;
      end else begin
        hit_q   <= hit_d;
        vaddr_q <= vaddr_d;
      end
    end

    assign hit   = hit_q;
    assign vaddr = vaddr_q;
  end else begin : g_comb
    assign hit   = hit_c;
    assign vaddr = vaddr_c;
  end

  // R3
  lin_full_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_sel == 2'd3) |-> hit_c);

  // R1
  legacy_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_sel == 2'd0 && !wide_win && hit_c) |->
      ((host_addr >> 16) == (AW'(LEGACY_BASE) >> 16)));

  // R7
  bankb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bankb_en) |-> (sel_b == BANK_A));

  // R5
  split_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bankb_en && split_rw) |-> (sel_b == (is_write ? BANK_B : BANK_A)));

  // R6
  half_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bankb_en && !split_rw && hit_c) |-> (sel_b == (upper_c ? BANK_A : BANK_B)));

endmodule

// File: tb/bank_window_mapper_bench.sv
module bank_window_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] host_addr = '0;
  logic        is_write = 1'b0;
  logic [6:0]  ofs_a = '0, ofs_b = '0;
  logic        split_rw = 1'b0, bankb_en = 1'b0, wide_win = 1'b0;
  logic [1:0]  map_sel = '0;
  logic        hit_c, hit_r;
  logic [19:0] vaddr_c, vaddr_r;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bank_window_mapper #(.REG_OUT(1'b0)) u_bank_window_mapper (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .is_write(is_write),
    .ofs_a(ofs_a), .ofs_b(ofs_b), .split_rw(split_rw), .bankb_en(bankb_en),
    .map_sel(map_sel), .wide_win(wide_win), .hit(hit_c), .vaddr(vaddr_c));

  bank_window_mapper #(.REG_OUT(1'b1)) u_bank_window_mapper_reg (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .is_write(is_write),
    .ofs_a(ofs_a), .ofs_b(ofs_b), .split_rw(split_rw), .bankb_en(bankb_en),
    .map_sel(map_sel), .wide_win(wide_win), .hit(hit_r), .vaddr(vaddr_r));

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Arithmetic model derived from the requirements; eb=1 means bank B.
  task automatic model(output logic eh, output logic [19:0] ev, output logic wrapped,
                       output string hreq, output string vreq);
    int base, size, loc, sum, ofs;
    logic eb;
    base = (map_sel == 2'd0) ? 'hA0000 : 0;
    size = (map_sel == 2'd0) ? (wide_win ? 'h20000 : 'h10000) : (1 << (17 + int'(map_sel)));
    loc  = int'(host_addr) - base;
    eh   = (loc >= 0) && (loc < size);
    if (!bankb_en)     eb = 1'b0;
    else if (split_rw) eb = is_write;
    else               eb = (loc < size / 2);
    ofs     = eb ? int'(ofs_b) : int'(ofs_a);
    sum     = loc + ofs * 4096;
    wrapped = (sum >= 'h100000);
    ev      = 20'(sum % 'h100000);
    hreq    = (map_sel != 2'd0) ? "R3" : (wide_win ? "R2" : "R1");
    vreq    = wrapped ? "R8" : (!bankb_en ? "R7" : (split_rw ? "R5" : "R6"));
  endtask

  // Inputs are already applied; clock once, then judge both variants.
  task automatic step_check();
    logic eh, wr;
    logic [19:0] ev;
    string hreq, vreq;
    model(eh, ev, wr, hreq, vreq);
    @(posedge clk);
    #1;
    chk(hreq, {19'd0, hit_c}, {19'd0, eh});
    chk("R9", {19'd0, hit_r}, {19'd0, eh});
    if (eh) begin
      chk(vreq, vaddr_c, ev);
      chk("R9", vaddr_r, ev);
    end
  endtask

  initial begin : watchdog
    #(8 * 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    // R9: outputs of the registered variant are cleared while reset is held.
    host_addr = 20'hA1000; map_sel = 2'd0; ofs_a = 7'h11;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", {19'd0, hit_r}, 20'd0);
    chk("R9", vaddr_r, 20'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R4: directed translation, map 0 wide, bank A only: B1234 -> 11234 + 3000.
    host_addr = 20'hB1234; wide_win = 1'b1; bankb_en = 1'b0; ofs_a = 7'h03;
    @(posedge clk);
    #1;
    chk("R4", vaddr_c, 20'h14234);
    chk("R4", {19'd0, hit_c}, 20'd1);

    // R4: narrow window, lower half uses bank B: A0010 -> 00010 + 5000.
    host_addr = 20'hA0010; wide_win = 1'b0; bankb_en = 1'b1; split_rw = 1'b0; ofs_b = 7'h05;
    @(posedge clk);
    #1;
    chk("R4", vaddr_c, 20'h05010);

    // R9: after an input change and before the next edge, only the comb variant follows.
    host_addr = 20'hC0000; map_sel = 2'd0;
    @(posedge clk);
    #1;
    host_addr = 20'hA0000;
    #1;
    chk("R9", {19'd0, hit_c}, 20'd1);
    chk("R9", {19'd0, hit_r}, 20'd0);
    @(posedge clk);
    #1;
    chk("R9", {19'd0, hit_r}, 20'd1);

    // Sweep every configuration, with both edges of each 2 KB step.
    for (int cfg = 0; cfg < 64; cfg++) begin
      map_sel  = cfg[1:0];
      wide_win = cfg[2];
      split_rw = cfg[3];
      bankb_en = cfg[4];
      is_write = cfg[5];
      ofs_a    = (cfg % 8 == 7) ? 7'h7F : 7'((cfg * 11 + 5) % 128);
      ofs_b    = 7'((cfg * 23 + 64) % 128);
      for (int k = 0; k < 512; k++) begin
        host_addr = 20'(k * 'h800);
        step_check();
        host_addr = 20'(k * 'h800 + 'h7FF);
        step_check();
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule